// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block moves a programmed run of words between one I/O device and system memory, so the processor does not have to copy each word. Software loads a start address and a word count, then writes a control word that picks the transfer direction and one of two bus-sharing modes and starts the run. The controller raises a bus request and waits for the grant. Once granted, it drives the memory address and the read or write strobe itself and strobes the device once for each word. After each word it steps the address up by one and the count down by one.

In burst mode the request stays high from the first word to the last, so the processor is locked out of the bus for the whole run. In cycle-stealing mode the controller drops the request for at least one cycle after every word and asks for the bus again before the next one, so the processor gets the bus between words. When the count reaches zero the request falls and a sticky done flag is raised. Software clears the flag with a control write.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: Register writes use `cfg_sel`. Code 0 loads the start address from `cfg_wdata`. Code 1 loads the word count from the low `CNT_W` bits of `cfg_wdata`. Code 2 is the control word, with bit 0 start, bit 1 mode (0 burst, 1 cycle stealing), bit 2 direction (0 device to memory, 1 memory to device) and bit 3 clear-done.
- R2: The k-th word moved (counting from 0) drives `mem_addr` = start + k and pulses `dev_stb` for exactly one cycle. Device to memory asserts `mem_wr` with `mem_wdata` equal to `dev_rdata`. Memory to device asserts `mem_rd` with `dev_wdata` equal to `mem_rdata`.
- R3: `mem_rd` and `mem_wr` are never high together. A memory or device strobe occurs only in a cycle whose preceding clock edge saw `bus_gnt` high.
- R4: In burst mode `bus_req` rises once per transfer and stays high until the last word. While the grant is held, successive words move in back-to-back cycles.
- R5: In cycle-stealing mode `bus_req` is low in the cycle after every word, so a transfer of N words raises the request N times.
- R6: If the grant is withdrawn during a burst, the controller pauses with the request still high. It resumes when the grant returns and keeps its address and remaining count, so the set of words and addresses is unchanged.
- R7: Starting with a count of zero sets `done` by the next cycle and never raises `bus_req`.
- R8: On completion `bus_req` and `busy` fall and `done` rises. `done` stays high until a control write with bit 3 set or a new start. Reset leaves every strobe, `bus_req`, `busy` and `done` low.
- R9: While `busy` is high, writes of address, count or start have no effect on the transfer in progress.
- R10: One transfer moves at most 2^`CNT_W` − 1 words. Count bits above `CNT_W` are discarded, so writing 2^`CNT_W` gives a zero-length transfer.
- R11: The address wraps modulo 2^`ADDR_W` when it steps past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | ADDR_W | Register write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Data written to memory |
| mem_rdata | input | DATA_W | Data read from memory |
| dev_stb | output | 1 | Device word strobe |
| dev_rdata | input | DATA_W | Data supplied by the device |
| dev_wdata | output | DATA_W | Data delivered to the device |

## Verification
Some properties are checked by assertions on every cycle:
- the two memory strobes never overlap, and no strobe occurs without a grant at the previous edge;
- in cycle-stealing mode the request drops after each word, and a granted burst moves on without a gap;
- a zero-length start never requests the bus, and the done flag stays set until it is cleared;
- the address and count registers hold still during a transfer except when a word moves.

Other behaviour only the bench scenarios can show: that each word lands at the right wrapped address with the right data in both directions, that the number of request pulses matches the mode, and that a withdrawn grant or writes made mid-transfer leave the moved words unchanged. The bench covers all count values, both modes and both directions.

// File: rtl/dma_xfer_pkg.sv
`timescale 1ns/1ps
package dma_xfer_pkg;

    // Register select codes on the configuration port
    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    // Control word bit positions
    localparam int CTL_GO_BIT    = 0;
    localparam int CTL_STEAL_BIT = 1;
    localparam int CTL_TODEV_BIT = 2;
    localparam int CTL_CLEAR_BIT = 3;
    localparam int CTL_BITS      = 4;

    typedef struct packed {
        logic clear;
        logic to_dev;
        logic steal;
        logic go;
    } ctl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MOVE = 2'd2,
        ST_GAP  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic dev;
    } strobe_t;

    function automatic ctl_t unpack_ctl(input logic [CTL_BITS-1:0] raw);
        ctl_t c;
        c.go     = raw[CTL_GO_BIT];
        c.steal  = raw[CTL_STEAL_BIT];
        c.to_dev = raw[CTL_TODEV_BIT];
        c.clear  = raw[CTL_CLEAR_BIT];
        return c;
    endfunction

    function automatic strobe_t make_strobe(input logic active, input logic to_dev);
        strobe_t s;
        s.rd  = active && to_dev;
        s.wr  = active && !to_dev;
        s.dev = active;
        return s;
    endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
`timescale 1ns/1ps
module dma_cfg_regs
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              busy,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              cnt_zero,
    output logic              cnt_last,
    output logic              start,
    output logic              start_steal,
    output logic              start_to_dev,
    output logic              clear
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    cfg_sel_e sel;
    ctl_t     cmd;
    logic     ctrl_hit;

    assign sel      = cfg_sel_e'(cfg_sel);
    assign cmd      = unpack_ctl(cfg_wdata[CTL_BITS-1:0]);
    assign ctrl_hit = cfg_we && (sel == SEL_CTRL);

    assign start        = ctrl_hit && cmd.go && !busy;
    assign start_steal  = cmd.steal;
    assign start_to_dev = cmd.to_dev;
    assign clear        = ctrl_hit && cmd.clear;

    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CNT_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (step) begin
            addr_q <= addr_q + ADDR_ONE;
            cnt_q  <= cnt_q - CNT_ONE;
        end else if (cfg_we && !busy) begin
            case (sel)
                SEL_ADDR:  addr_q <= cfg_wdata;
                SEL_COUNT: cnt_q  <= cfg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && !step) |=> ($stable(addr_q) && $stable(cnt_q))); // R9

    AST_STEP_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
        step |=> (cnt_q == $past(cnt_q) - CNT_ONE) && (addr_q == $past(addr_q) + ADDR_ONE)); // R11

endmodule

// File: rtl/dma_seq.sv
`timescale 1ns/1ps
module dma_seq
    import dma_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_steal,
    input  logic start_to_dev,
    input  logic clear,
    input  logic cnt_zero,
    input  logic cnt_last,
    input  logic bus_gnt,
    output logic busy,
    output logic done,
    output logic bus_req,
    output logic move,
    output logic to_dev_q
);
    seq_state_e state_q, state_d;
    logic       steal_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start && !cnt_zero) state_d = ST_WAIT;
            ST_WAIT: if (bus_gnt) state_d = ST_MOVE;
            ST_MOVE: begin
                if (cnt_last)     state_d = ST_IDLE;
                else if (steal_q) state_d = ST_GAP;
                else if (bus_gnt) state_d = ST_MOVE;
                else              state_d = ST_WAIT;
            end
            ST_GAP:  state_d = ST_WAIT;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            steal_q  <= 1'b0;
            to_dev_q <= 1'b0;
            done     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                steal_q  <= start_steal;
                to_dev_q <= start_to_dev;
                done     <= cnt_zero;
            end else if (move && cnt_last) begin
                done <= 1'b1;
            end else if (clear) begin
                done <= 1'b0;
            end
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign move    = (state_q == ST_MOVE);
    assign bus_req = (state_q == ST_WAIT) || (state_q == ST_MOVE);

    AST_ZERO_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (start && cnt_zero) |=> (!bus_req && done)); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done && !clear && !start) |=> done); // R8

    AST_COMPLETE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (move && cnt_last) |=> (!bus_req && !busy && done)); // R8

    AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (move && steal_q) |=> !bus_req); // R5

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (move && !steal_q && !cnt_last && bus_gnt) |=> move); // R4

    AST_PAUSE_KEEPS_REQ: assert property (@(posedge clk) disable iff (rst)
        (move && !steal_q && !cnt_last && !bus_gnt) |=> (bus_req && !move)); // R6

endmodule

// File: rtl/dma_bus_drive.sv
`timescale 1ns/1ps
module dma_bus_drive
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              move,
    input  logic              to_dev,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dev_stb,
    output logic [DATA_W-1:0] dev_wdata
);
    strobe_t stb;

    assign stb      = make_strobe(move, to_dev);
    assign mem_rd   = stb.rd;
    assign mem_wr   = stb.wr;
    assign dev_stb  = stb.dev;
    assign mem_addr = move ? addr_q : '0;

    // Per-bit data gating toward each side of the copy
    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
        assign mem_wdata[b] = stb.wr && dev_rdata[b];
        assign dev_wdata[b] = stb.rd && mem_rdata[b];
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr})); // R3

    AST_DEV_WITH_MEM: assert property (@(posedge clk) disable iff (rst)
        dev_stb == (mem_rd || mem_wr)); // R2

endmodule

// File: rtl/dma_xfer_ctrl.sv
`timescale 1ns/1ps
module dma_xfer_ctrl
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              busy,
    output logic              done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              dev_stb,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0] dev_wdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic cnt_zero, cnt_last;
    logic start, start_steal, start_to_dev, clear;
    logic move, to_dev_q;

    dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy), .step(move),
        .addr_q(addr_q), .cnt_q(cnt_q),
        .cnt_zero(cnt_zero), .cnt_last(cnt_last),
        .start(start), .start_steal(start_steal),
        .start_to_dev(start_to_dev), .clear(clear)
    );

    dma_seq u_seq (
        .clk(clk), .rst(rst),
        .start(start), .start_steal(start_steal), .start_to_dev(start_to_dev),
        .clear(clear), .cnt_zero(cnt_zero), .cnt_last(cnt_last),
        .bus_gnt(bus_gnt),
        .busy(busy), .done(done), .bus_req(bus_req),
        .move(move), .to_dev_q(to_dev_q)
    );

    dma_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .clk(clk), .rst(rst),
        .move(move), .to_dev(to_dev_q), .addr_q(addr_q),
        .mem_rdata(mem_rdata), .dev_rdata(dev_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .dev_stb(dev_stb), .dev_wdata(dev_wdata)
    );

    AST_STROBE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> $past(bus_gnt)); // R3

    AST_STROBE_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        dev_stb |-> bus_req); // R3

endmodule

// File: tb/dma_xfer_ctrl_test.sv
`timescale 1ns/1ps
module dma_xfer_ctrl_test;
    localparam int AW = 8;
    localparam int CW = 4;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic busy, done, bus_req, mem_rd, mem_wr, dev_stb;
    logic bus_gnt = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, dev_rdata, dev_wdata;

    logic [DW-1:0] mem [0:255];
    int  dev_idx = 0;
    logic [7:0] seed = 8'd0;

    int n_chk = 0, n_fail = 0;
    int words = 0, addr_err = 0, data_err = 0, kind_err = 0, req_rises = 0;
    int cyc = 0, first_cyc = -1, last_cyc = -1;
    int exp_start = 0;
    bit cur_to_dev = 0, hold_test = 0, held_once = 0;
    int hold_cnt = 0;
    logic req_prev = 1'b0;

    always #2 clk = ~clk;

    dma_xfer_ctrl #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy), .done(done), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_stb(dev_stb), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata)
    );

    assign mem_rdata = mem[mem_addr];
    assign dev_rdata = DW'(dev_idx * 7 + int'(seed));

    // Bus arbiter stub: grant follows request one half cycle later, with optional hold-off
    always @(negedge clk) begin
        if (rst) begin
            bus_gnt <= 1'b0;
        end else begin
            if (hold_test && !held_once && words == 3) begin
                held_once = 1;
                hold_cnt  = 4;
            end
            if (hold_cnt > 0) begin
                hold_cnt = hold_cnt - 1;
                bus_gnt <= 1'b0;
            end else begin
                bus_gnt <= bus_req;
            end
        end
    end

    // Monitor, sampling one time unit after each rising edge
    always begin
        @(posedge clk);
        #1;
        cyc = cyc + 1;
        if (!rst) begin
            if (bus_req && !req_prev) req_rises = req_rises + 1;
            req_prev = bus_req;
            if (mem_rd || mem_wr) begin
                int ea;
                ea = (exp_start + words) & 255;
                if (int'(mem_addr) != ea) addr_err = addr_err + 1;
                if (!bus_gnt) kind_err = kind_err + 1;
                if (!dev_stb) kind_err = kind_err + 1;
                if (cur_to_dev) begin
                    if (!mem_rd || mem_wr) kind_err = kind_err + 1;
                    if (dev_wdata != (DW'(ea) ^ seed)) data_err = data_err + 1;
                end else begin
                    if (!mem_wr || mem_rd) kind_err = kind_err + 1;
                    if (mem_wdata != DW'(words * 7 + int'(seed))) data_err = data_err + 1;
                    mem[mem_addr] = mem_wdata;
                end
                if (first_cyc < 0) first_cyc = cyc;
                last_cyc = cyc;
                words   = words + 1;
                dev_idx = dev_idx + 1;
            end else if (dev_stb) begin
                kind_err = kind_err + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [AW-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run(input int start, input int cnt_wr, input int exp_words,
                       input bit steal, input bit to_dev, input bit hold, input bit poke);
        int t;
        seed = 8'(start ^ (cnt_wr * 5) ^ (to_dev ? 8'h5A : 8'h00));
        for (int i = 0; i < 256; i++) mem[i] = DW'(i) ^ seed;
        words = 0; addr_err = 0; data_err = 0; kind_err = 0; req_rises = 0;
        first_cyc = -1; last_cyc = -1; dev_idx = 0;
        exp_start = start; cur_to_dev = to_dev; hold_test = hold; held_once = 0;
        cfg_write(2'd0, AW'(start));
        cfg_write(2'd1, AW'(cnt_wr));
        cfg_write(2'd2, AW'({to_dev, steal, 1'b1}));
        if (poke) begin
            // R9: writes while busy must not disturb the running transfer
            cfg_write(2'd0, AW'(start + 100));
            cfg_write(2'd1, AW'(1));
            cfg_write(2'd2, AW'({~to_dev, ~steal, 1'b1}));
        end
        t = 0;
        while (!done && t < 400) begin
            @(negedge clk);
            t = t + 1;
        end
        repeat (3) @(negedge clk);
        check(words == exp_words, poke ? "R9 word count" : (hold ? "R6 word count" : "R2 word count"),
              words, exp_words);
        check(addr_err == 0, "R11 address sequence", addr_err, 0);
        check(data_err == 0, "R2 data", data_err, 0);
        check(kind_err == 0, "R3 strobe kind/grant", kind_err, 0);
        if (exp_words == 0)
            check(req_rises == 0, "R7 zero count request", req_rises, 0);
        else if (steal)
            check(req_rises == exp_words, "R5 request pulses", req_rises, exp_words);
        else
            check(req_rises == 1, "R4 request pulses", req_rises, 1);
        if (!steal && !hold && exp_words > 0)
            check(last_cyc - first_cyc == exp_words - 1, "R4 back-to-back words",
                  last_cyc - first_cyc, exp_words - 1);
        check(done && !bus_req && !busy, "R8 completion state",
              {29'd0, done, bus_req, busy}, 4);
        cfg_write(2'd2, AW'(8'h08));
        check(!done, "R8 done clear", done, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !bus_req && !mem_rd && !mem_wr && !dev_stb,
              "R8 reset state", {26'd0, busy, done, bus_req, mem_rd, mem_wr, dev_stb}, 0);

        // R1 R2 R4 R5: full sweep of counts, modes and directions
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 16; c++) begin
                run((c * 37 + m * 11 + 200) & 255, c, c, m[0], m[1], 1'b0, 1'b0);
            end
        end

        // R11: explicit wrap past the top of the address space
        run(8'hFA, 10, 10, 1'b0, 1'b0, 1'b0, 1'b0);
        run(8'hFE, 5, 5, 1'b1, 1'b1, 1'b0, 1'b0);

        // R6: grant withdrawn mid-burst, both directions
        run(8'h20, 12, 12, 1'b0, 1'b0, 1'b1, 1'b0);
        run(8'h40, 15, 15, 1'b0, 1'b1, 1'b1, 1'b0);

        // R9: writes during an active transfer
        run(8'h60, 9, 9, 1'b1, 1'b0, 1'b0, 1'b1);
        run(8'h80, 14, 14, 1'b1, 1'b1, 1'b0, 1'b1);

        // R10: count width cap and truncation
        run(8'h10, 8'h1F, 15, 1'b0, 1'b0, 1'b0, 1'b0);
        run(8'h10, 8'h10, 0, 1'b0, 1'b1, 1'b0, 1'b0);

        // R7 R8: zero-length start sets done by the next cycle and it stays set
        cfg_write(2'd1, AW'(0));
        cfg_write(2'd2, AW'(8'h01));
        check(done && !bus_req, "R7 immediate done", {30'd0, done, bus_req}, 2);
        repeat (5) @(negedge clk);
        check(done, "R8 done sticky", done, 1);
        cfg_write(2'd2, AW'(8'h08));
        check(!done, "R8 done cleared", done, 0);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk  = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

endmodule